// File: doc/BRIEF.md
# Aggregated Receive Buffer Status Parser

This block walks one receive buffer that holds several packets packed back to back by an upstream aggregation engine. The buffer arrives as a stream of 32-bit little-endian words, and a status record of eight words stands in front of every packet. The parser decodes each record and works out how many bytes the packet takes up, including alignment padding and an optional checksum trailer. It decides whether the packet is delivered or dropped, and forwards only the payload words on a valid/ready output stream. Each payload word carries start, end, valid-byte and drop markers.

A buffer starts with a one-cycle `buf_start` pulse that gives the buffer's byte count. The parser then pulls words until that count is used up and returns to idle. Status records that carry a valid tag report back to the control path. A tag from the command endpoint gives a completion pulse, and a tag from any other source sets an error flag. A buffer that claims more bytes than it holds sets an overrun flag, and the rest of the buffer is thrown away.

Top module: `aggr_status_parser`

## Requirements
- R1: A `buf_start` pulse while idle loads `buf_bytes`/4 as the word budget, sets `busy`, and clears `tag_err` and `overrun_err`. A `buf_start` pulse while busy is ignored. Out of reset the block is idle, with `in_ready`, `out_valid`, `cmd_done`, `tag_err` and `overrun_err` all low.
- R2: Each packet record is eight words: word 0 = {tag mask[31:16], exception[15:8], opcode[7:0]} and word 1 = {source endpoint[20:16], length[15:0]}. Only the payload is emitted, at ceil(length/4) beats. `out_sop` marks the first beat and `out_eop` the last. `out_bytes` is 4 on every beat except the last, where it is length mod 4 (0 reads as 4).
- R3: Opcodes 0x01, 0x02, 0x04 and 0x40 are packet records. A record with any other opcode is consumed as eight words and produces no output.
- R4: A packet record with length 0 is consumed as eight words and produces no output.
- R5: After its record, a packet takes roundup(length, A) bytes, plus 8 when `trailer_en` is 1. A is `pad_align`, and a value of 0 counts as 1. Pad and trailer words are consumed but not emitted.
- R6: A non-zero tag mask drops the packet. If the source endpoint equals `cmd_ep`, `cmd_done` pulses for one cycle. Otherwise `tag_err` is set and stays set until the next accepted start.
- R7: With a zero tag mask, a non-zero exception code drops the packet only when the code is 0x01 (deaggregation). Any other code delivers it.
- R8: With a zero tag mask and a zero exception code, the packet is dropped only when the rule index (word 3 bits 31:22) is 0x3FF.
- R9: When fewer than eight words remain at a record boundary, they are consumed and discarded without any error, and the block returns to idle.
- R10: When a packet's span exceeds the words left after its record, `overrun_err` is set. The remaining words are discarded with no output and no tag report.
- R11: While `out_ready` is low a beat is held unchanged and no input word is taken. `out_drop` is the same on every beat of a packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pad_align | input | ALIGN_W | Payload alignment in bytes (power of two, 0 = 1) |
| trailer_en | input | 1 | An 8-byte checksum trailer follows each packet |
| cmd_ep | input | 5 | Endpoint ID of the command source |
| buf_start | input | 1 | Starts a buffer (taken only while idle) |
| buf_bytes | input | BUF_W | Byte count of the buffer |
| busy | output | 1 | A buffer is being walked |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted |
| in_data | input | 32 | Buffer word, little-endian |
| out_valid | output | 1 | Payload beat valid |
| out_ready | input | 1 | Sink accepts the beat |
| out_data | output | 32 | Payload word |
| out_bytes | output | 3 | Valid bytes in the beat (1..4) |
| out_sop | output | 1 | First beat of a packet |
| out_eop | output | 1 | Last beat of a packet |
| out_drop | output | 1 | Packet is to be discarded |
| cmd_done | output | 1 | One-cycle pulse: command tag seen |
| tag_err | output | 1 | Tag from an unexpected source seen |
| overrun_err | output | 1 | A packet ran past the end of the buffer |

## Verification
The assertions assume three things about the inputs. While the block is busy, the source holds a word steady until it is taken. The configuration does not change during a buffer. Every packet span is a whole number of words, which means `pad_align` is a power of two and any length that is not a multiple of four is rounded up by an alignment of at least four. The stimulus keeps within these limits: it holds each offered word until it is accepted, changes the configuration only between buffers, and pairs odd lengths with an alignment of 4 or more. Gaps on the input and back-pressure on the output are random.

// File: rtl/aggr_status_pkg.sv
// Shared constants and types for the aggregated receive buffer status parser.
// Assumes the fixed record layout: eight 32-bit words ahead of each payload.
package aggr_status_pkg;
    localparam int REC_WORDS     = 8;
    localparam int LEN_W         = 16;
    localparam int EP_W          = 5;
    localparam int RULE_W        = 10;
    localparam int TRAILER_BYTES = 8;

    localparam logic [7:0] OP_PACKET      = 8'h01;
    localparam logic [7:0] OP_DROPPED     = 8'h02;
    localparam logic [7:0] OP_SUSPENDED   = 8'h04;
    localparam logic [7:0] OP_SECOND_PASS = 8'h40;
    localparam logic [7:0] EXC_DEAGGR     = 8'h01;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_PAY,
        ST_SKIP,
        ST_DRAIN
    } walk_state_e;

    // True for opcodes whose record describes a packet payload
    function automatic logic is_pkt_op(input logic [7:0] op);
        return (op == OP_PACKET) || (op == OP_DROPPED) ||
               (op == OP_SUSPENDED) || (op == OP_SECOND_PASS);
    endfunction
endpackage

// File: rtl/aggr_rec_decode.sv
// Combinational decode of one captured status record: payload presence,
// payload and span lengths in words, tail byte count and the drop verdict.
// Assumes pad_align is zero or a power of two and the span is word aligned.
module aggr_rec_decode
    import aggr_status_pkg::*;
#(
    parameter int ALIGN_W = 8,
    parameter int SPAN_W  = LEN_W + 2
) (
    input  logic [31:0]         hdr_w0,
    input  logic [20:0]         hdr_w1,
    input  logic [RULE_W-1:0]   hdr_rule,
    input  logic [ALIGN_W-1:0]  pad_align,
    input  logic                trailer_en,
    input  logic [EP_W-1:0]     cmd_ep,
    output logic                has_payload,
    output logic [SPAN_W-1:0]   pay_words,
    output logic [SPAN_W-1:0]   span_words,
    output logic [SPAN_W-1:0]   skip_words,
    output logic [2:0]          tail_bytes,
    output logic                drop,
    output logic                tag_seen,
    output logic                tag_is_cmd
);
    logic [7:0]        opcode;
    logic [7:0]        exc_code;
    logic [15:0]       tag_mask;
    logic [LEN_W-1:0]  pkt_len;
    logic [SPAN_W-1:0] len_x;
    logic [SPAN_W-1:0] align_eff;
    logic [SPAN_W-1:0] rounded;
    logic [SPAN_W-1:0] span_bytes;

    // Field extraction from the captured words
    always_comb begin
        opcode   = hdr_w0[7:0];
        exc_code = hdr_w0[15:8];
        tag_mask = hdr_w0[31:16];
        pkt_len  = hdr_w1[LEN_W-1:0];
    end

    // Length arithmetic: alignment round-up, trailer, word counts
    always_comb begin
        len_x      = SPAN_W'(pkt_len);
        align_eff  = (pad_align == '0) ? SPAN_W'(1) : SPAN_W'(pad_align);
        rounded    = (len_x + align_eff - SPAN_W'(1)) & ~(align_eff - SPAN_W'(1));
        span_bytes = rounded + (trailer_en ? SPAN_W'(TRAILER_BYTES) : '0);
        span_words = span_bytes >> 2;
        pay_words  = (len_x + SPAN_W'(3)) >> 2;
        skip_words = span_words - pay_words;
        tail_bytes = (pkt_len[1:0] == 2'b00) ? 3'd4 : {1'b0, pkt_len[1:0]};
    end

    // Delivery verdict in priority order: tag, exception, routing miss
    always_comb begin
        has_payload = is_pkt_op(opcode) && (pkt_len != '0);
        tag_seen    = (tag_mask != '0);
        tag_is_cmd  = (hdr_w1[16 +: EP_W] == cmd_ep);
        if (tag_seen)
            drop = 1'b1;
        else if (exc_code != 8'h00)
            drop = (exc_code == EXC_DEAGGR);
        else
            drop = (hdr_rule == {RULE_W{1'b1}});
    end
endmodule

// File: rtl/aggr_walker.sv
// Buffer walker: counts the word budget, captures record fields, forwards
// payload words, skips pad and trailer words and drains tails or overruns.
// Assumes the source holds a word until accepted and config is stable.
module aggr_walker
    import aggr_status_pkg::*;
#(
    parameter int BUF_W  = 16,
    parameter int SPAN_W = LEN_W + 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               buf_start,
    input  logic [BUF_W-1:0]   buf_bytes,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [31:0]        in_data,
    output logic               out_valid,
    input  logic               out_ready,
    output logic               out_sop,
    output logic               out_eop,
    output logic [2:0]         out_bytes,
    output logic               out_drop,
    output logic               busy,
    output logic               cmd_done,
    output logic               tag_err,
    output logic               overrun_err,
    output logic [31:0]        hdr_w0,
    output logic [20:0]        hdr_w1,
    output logic [RULE_W-1:0]  hdr_rule,
    input  logic               has_payload,
    input  logic [SPAN_W-1:0]  pay_words,
    input  logic [SPAN_W-1:0]  span_words,
    input  logic [SPAN_W-1:0]  skip_words,
    input  logic [2:0]         tail_bytes,
    input  logic               drop,
    input  logic               tag_seen,
    input  logic               tag_is_cmd
);
    localparam int CMP_W = (BUF_W > SPAN_W) ? BUF_W : SPAN_W;

    walk_state_e       state_q;
    logic [BUF_W-1:0]  rem_q;
    logic [BUF_W-1:0]  rem_nx;
    logic [BUF_W-1:0]  load_words;
    logic [2:0]        hdr_idx_q;
    logic [SPAN_W-1:0] pay_q;
    logic [SPAN_W-1:0] skip_q;
    logic [2:0]        tail_q;
    logic              drop_q, sop_q, done_q, tag_err_q, ovr_q;
    logic              acc;

    // Where to go once a record (and its payload) is fully consumed
    function automatic walk_state_e after_rec(input logic [BUF_W-1:0] r);
        if (r == '0)
            return ST_IDLE;
        else if (r < BUF_W'(REC_WORDS))
            return ST_DRAIN;
        return ST_HDR;
    endfunction

    // Handshake and output markers
    always_comb begin
        busy        = (state_q != ST_IDLE);
        in_ready    = (state_q == ST_HDR) || (state_q == ST_SKIP) ||
                      (state_q == ST_DRAIN) || ((state_q == ST_PAY) && out_ready);
        acc         = in_valid && in_ready;
        rem_nx      = rem_q - BUF_W'(1);
        load_words  = buf_bytes >> 2;
        out_valid   = (state_q == ST_PAY) && in_valid;
        out_sop     = sop_q;
        out_eop     = (pay_q == SPAN_W'(1));
        out_bytes   = out_eop ? tail_q : 3'd4;
        out_drop    = drop_q;
        cmd_done    = done_q;
        tag_err     = tag_err_q;
        overrun_err = ovr_q;
    end

    // Walk state, word budget, record capture and status flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            rem_q     <= '0;
            hdr_idx_q <= '0;
            pay_q     <= '0;
            skip_q    <= '0;
            tail_q    <= 3'd4;
            drop_q    <= 1'b0;
            sop_q     <= 1'b0;
            done_q    <= 1'b0;
            tag_err_q <= 1'b0;
            ovr_q     <= 1'b0;
            hdr_w0    <= '0;
            hdr_w1    <= '0;
            hdr_rule  <= '0;
        end else begin
            done_q <= 1'b0;
            if (state_q == ST_IDLE) begin
                if (buf_start) begin
                    rem_q     <= load_words;
                    hdr_idx_q <= '0;
                    tag_err_q <= 1'b0;
                    ovr_q     <= 1'b0;
                    state_q   <= after_rec(load_words);
                end
            end else if (acc) begin
                rem_q <= rem_nx;
                case (state_q)
                    ST_HDR: begin
                        hdr_idx_q <= hdr_idx_q + 3'd1;
                        case (hdr_idx_q)
                            3'd0:    hdr_w0   <= in_data;
                            3'd1:    hdr_w1   <= in_data[20:0];
                            3'd3:    hdr_rule <= in_data[31:32-RULE_W];
                            default: ;
                        endcase
                        if (hdr_idx_q == 3'd7) begin
                            if (!has_payload) begin
                                state_q <= after_rec(rem_nx);
                            end else if (CMP_W'(span_words) > CMP_W'(rem_nx)) begin
                                ovr_q   <= 1'b1;
                                state_q <= (rem_nx == '0) ? ST_IDLE : ST_DRAIN;
                            end else begin
                                state_q   <= ST_PAY;
                                pay_q     <= pay_words;
                                skip_q    <= skip_words;
                                tail_q    <= tail_bytes;
                                drop_q    <= drop;
                                sop_q     <= 1'b1;
                                done_q    <= tag_seen && tag_is_cmd;
                                tag_err_q <= tag_err_q || (tag_seen && !tag_is_cmd);
                            end
                        end
                    end
                    ST_PAY: begin
                        sop_q <= 1'b0;
                        pay_q <= pay_q - SPAN_W'(1);
                        if (pay_q == SPAN_W'(1))
                            state_q <= (skip_q != '0) ? ST_SKIP : after_rec(rem_nx);
                    end
                    ST_SKIP: begin
                        skip_q <= skip_q - SPAN_W'(1);
                        if (skip_q == SPAN_W'(1))
                            state_q <= after_rec(rem_nx);
                    end
                    ST_DRAIN: begin
                        if (rem_nx == '0)
                            state_q <= ST_IDLE;
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/aggr_status_parser.sv
// Top of the aggregated receive buffer status parser: ties the record
// decoder to the buffer walker. Payload words pass straight through.
// Assumes the source holds words until accepted and config is stable per buffer.
module aggr_status_parser
    import aggr_status_pkg::*;
#(
    parameter int BUF_W   = 16,
    parameter int ALIGN_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ALIGN_W-1:0] pad_align,
    input  logic               trailer_en,
    input  logic [EP_W-1:0]    cmd_ep,
    input  logic               buf_start,
    input  logic [BUF_W-1:0]   buf_bytes,
    output logic               busy,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [31:0]        in_data,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [31:0]        out_data,
    output logic [2:0]         out_bytes,
    output logic               out_sop,
    output logic               out_eop,
    output logic               out_drop,
    output logic               cmd_done,
    output logic               tag_err,
    output logic               overrun_err
);
    localparam int SPAN_W = LEN_W + 2;

    logic [31:0]       hdr_w0;
    logic [20:0]       hdr_w1;
    logic [RULE_W-1:0] hdr_rule;
    logic              has_payload, drop, tag_seen, tag_is_cmd;
    logic [SPAN_W-1:0] pay_words, span_words, skip_words;
    logic [2:0]        tail_bytes;

    // Payload is forwarded without storage
    assign out_data = in_data;

    aggr_rec_decode #(.ALIGN_W(ALIGN_W), .SPAN_W(SPAN_W)) u_decode (
        .hdr_w0(hdr_w0), .hdr_w1(hdr_w1), .hdr_rule(hdr_rule),
        .pad_align(pad_align), .trailer_en(trailer_en), .cmd_ep(cmd_ep),
        .has_payload(has_payload), .pay_words(pay_words),
        .span_words(span_words), .skip_words(skip_words),
        .tail_bytes(tail_bytes), .drop(drop),
        .tag_seen(tag_seen), .tag_is_cmd(tag_is_cmd)
    );

    aggr_walker #(.BUF_W(BUF_W), .SPAN_W(SPAN_W)) u_walker (
        .clk(clk), .rst_n(rst_n), .buf_start(buf_start), .buf_bytes(buf_bytes),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_sop(out_sop), .out_eop(out_eop), .out_bytes(out_bytes),
        .out_drop(out_drop), .busy(busy), .cmd_done(cmd_done),
        .tag_err(tag_err), .overrun_err(overrun_err),
        .hdr_w0(hdr_w0), .hdr_w1(hdr_w1), .hdr_rule(hdr_rule),
        .has_payload(has_payload), .pay_words(pay_words),
        .span_words(span_words), .skip_words(skip_words),
        .tail_bytes(tail_bytes), .drop(drop),
        .tag_seen(tag_seen), .tag_is_cmd(tag_is_cmd)
    );
endmodule

// File: rtl/aggr_status_parser_chk.sv
// Protocol checker for the status parser, attached through bind.
// Assumes the source holds an offered word while the block is busy.
module aggr_status_parser_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        buf_start,
    input logic        busy,
    input logic        in_valid,
    input logic        in_ready,
    input logic [31:0] in_data,
    input logic        out_valid,
    input logic        out_ready,
    input logic [31:0] out_data,
    input logic        out_sop,
    input logic        out_eop,
    input logic [2:0]  out_bytes,
    input logic        out_drop,
    input logic        cmd_done,
    input logic        tag_err,
    input logic        overrun_err
);
    // R1: idle block neither takes words nor offers beats
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!in_ready && !out_valid));

    // R1: a start while busy leaves the walk running
    p_start_ignored_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && buf_start && !(in_valid && in_ready)) |=> busy);

    // R2: only the last beat may carry fewer than four bytes
    p_full_beats_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_eop) |-> (out_bytes == 3'd4));

    // R6: completion is a single-cycle pulse
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |=> !cmd_done);

    // R6: tag error holds until a new buffer is accepted
    p_tag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tag_err && !(buf_start && !busy)) |=> tag_err);

    // R10: overrun holds until a new buffer is accepted
    p_overrun_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun_err && !(buf_start && !busy)) |=> overrun_err);

    // R11: input side of the handshake holds while busy (stimulus assumption)
    p_in_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && in_valid && !in_ready) |=> (in_valid && $stable(in_data)));

    // R11: a stalled beat stays unchanged
    p_out_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) &&
            $stable(out_sop) && $stable(out_eop) && $stable(out_drop)));

    // R11: a taken beat consumes exactly its input word
    p_beat_consumes_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready) |-> in_ready);
endmodule

bind aggr_status_parser aggr_status_parser_chk u_chk (.*);

// File: tb/aggr_status_parser_tb.sv
`timescale 1ns/1ps
module aggr_status_parser_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  pad_align;
    logic        trailer_en;
    logic [4:0]  cmd_ep;
    logic        buf_start;
    logic [15:0] buf_bytes;
    logic        busy;
    logic        in_valid;
    logic        in_ready;
    logic [31:0] in_data;
    logic        out_valid;
    logic        out_ready;
    logic [31:0] out_data;
    logic [2:0]  out_bytes;
    logic        out_sop, out_eop, out_drop;
    logic        cmd_done, tag_err, overrun_err;

    logic [38:0] exp_q[$];
    string       tag_q[$];
    logic [31:0] wq[$];
    int checks = 0;
    int errors = 0;
    int done_cnt = 0;
    int seq = 0;

    always #10 clk = ~clk;

    aggr_status_parser u_dut (
        .clk(clk), .rst_n(rst_n), .pad_align(pad_align), .trailer_en(trailer_en),
        .cmd_ep(cmd_ep), .buf_start(buf_start), .buf_bytes(buf_bytes), .busy(busy),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_bytes(out_bytes), .out_sop(out_sop), .out_eop(out_eop),
        .out_drop(out_drop), .cmd_done(cmd_done), .tag_err(tag_err),
        .overrun_err(overrun_err)
    );

    task automatic check(input bit ok, input string rq, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    // Driver: push record words and the expected payload beats
    task automatic add_rec(input logic [7:0] op, input logic [7:0] exc,
                           input logic [15:0] tg, input logic [4:0] src,
                           input logic [9:0] rule, input int len, input string rq);
        int a, rounded, span, pw, sw, tb;
        bit pkt, drp;
        logic [31:0] d;
        wq.push_back({tg, exc, op});
        wq.push_back({11'd0, src, 16'(len)});
        wq.push_back(32'h0);
        wq.push_back({rule, 22'd0});
        repeat (4) wq.push_back(32'h0);
        pkt = ((op == 8'h01) || (op == 8'h02) || (op == 8'h04) || (op == 8'h40)) && (len != 0);
        if (!pkt) return;
        a = (pad_align == 0) ? 1 : int'(pad_align);
        rounded = ((len + a - 1) / a) * a;
        span = rounded + (trailer_en ? 8 : 0);
        pw = (len + 3) / 4;
        sw = span / 4 - pw;
        if (tg != 0) drp = 1'b1;
        else if (exc != 0) drp = (exc == 8'h01);
        else drp = (rule == 10'h3FF);
        seq++;
        for (int i = 0; i < pw; i++) begin
            d = {8'(seq), 8'(i), 16'hC35A};
            wq.push_back(d);
            tb = (i == pw - 1) ? ((len % 4 == 0) ? 4 : len % 4) : 4;
            exp_q.push_back({drp, (i == 0), (i == pw - 1), 3'(tb), d});
            tag_q.push_back(rq);
        end
        for (int i = 0; i < sw; i++) wq.push_back(32'hEEEE_0000 | 32'(i));
    endtask

    // Feeds the queued words and monitors beats against the scoreboard
    task automatic run_buffer(input int bytes, input int ignore_at);
        int idx = 0;
        int cyc = 0;
        bit hold = 0;
        bit acc;
        logic [38:0] e;
        logic [38:0] act;
        string rq;
        @(negedge clk);
        buf_bytes = 16'(bytes);
        buf_start = 1'b1;
        @(negedge clk);
        buf_start = 1'b0;
        check(!tag_err && !overrun_err, "R1", "flags cleared at start",
              {tag_err, overrun_err}, 0);
        done_cnt = 0;
        while (!(idx == wq.size() && !busy)) begin
            if (!hold) begin
                if (idx < wq.size() && $urandom_range(0, 3) != 0) begin
                    in_valid = 1'b1;
                    in_data = wq[idx];
                end else in_valid = 1'b0;
            end
            out_ready = ($urandom_range(0, 3) != 0);
            if (cyc == ignore_at) begin
                buf_start = 1'b1;
                buf_bytes = 16'h0100;
            end else buf_start = 1'b0;
            #2;
            if (cyc == ignore_at + 1)
                check(busy, "R1", "start while busy ignored", busy, 1);
            acc = in_valid && in_ready;
            if (acc) idx++;
            hold = in_valid && !acc;
            if (out_valid && out_ready) begin
                act = {out_drop, out_sop, out_eop, out_bytes, out_data};
                if (exp_q.size() == 0) begin
                    check(0, "R2", "unexpected beat", act, 0);
                end else begin
                    e = exp_q.pop_front();
                    rq = tag_q.pop_front();
                    check(act == e, rq, "beat (with R11 handshake)", act, e);
                end
            end
            if (cmd_done) done_cnt++;
            @(negedge clk);
            cyc++;
        end
        in_valid = 1'b0;
        buf_start = 1'b0;
        out_ready = 1'b0;
        check(exp_q.size() == 0, "R2", "beats missing at end", exp_q.size(), 0);
        exp_q.delete();
        tag_q.delete();
        wq.delete();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        pad_align = 8'd4;
        trailer_en = 1'b0;
        cmd_ep = 5'd3;
        buf_start = 1'b0;
        buf_bytes = '0;
        in_valid = 1'b0;
        in_data = '0;
        out_ready = 1'b0;
        repeat (3) @(negedge clk);
        check(!busy && !in_ready && !out_valid, "R1", "reset idle",
              {busy, in_ready, out_valid}, 0);
        check(!cmd_done && !tag_err && !overrun_err, "R1", "reset flags",
              {cmd_done, tag_err, overrun_err}, 0);
        rst_n = 1'b1;

        // Buffer A: mixed verdicts, align 4, no trailer, short tail
        pad_align = 8'd4; trailer_en = 1'b0;
        add_rec(8'h01, 8'h00, 16'h0000, 5'd9, 10'd0, 12, "R2");
        add_rec(8'h02, 8'h00, 16'h0000, 5'd9, 10'd0, 5, "R5");
        add_rec(8'h10, 8'h00, 16'h0000, 5'd9, 10'd0, 16, "R3");
        add_rec(8'h01, 8'h00, 16'h0000, 5'd9, 10'd0, 0, "R4");
        add_rec(8'h04, 8'h00, 16'h0001, 5'd3, 10'd0, 8, "R6");
        add_rec(8'h01, 8'h01, 16'h0000, 5'd9, 10'd0, 4, "R7");
        add_rec(8'h01, 8'h05, 16'h0000, 5'd9, 10'd0, 4, "R7");
        add_rec(8'h01, 8'h00, 16'h0000, 5'd9, 10'h3FF, 8, "R8");
        add_rec(8'h01, 8'h00, 16'h0000, 5'd9, 10'h3FE, 4, "R8");
        add_rec(8'h40, 8'h00, 16'h0000, 5'd9, 10'd0, 8, "R3");
        repeat (3) wq.push_back(32'h1234_0000);
        run_buffer(wq.size() * 4, 20);
        check(done_cnt == 1, "R6", "command completion pulses", done_cnt, 1);
        check(!tag_err, "R6", "no tag error for command source", tag_err, 0);
        check(!overrun_err && !busy, "R9", "short tail drained cleanly",
              {overrun_err, busy}, 0);

        // Buffer B: alignment 0 with trailer, foreign tag
        pad_align = 8'd0; trailer_en = 1'b1;
        add_rec(8'h01, 8'h00, 16'h0000, 5'd9, 10'd0, 8, "R5");
        add_rec(8'h02, 8'h00, 16'h8000, 5'd7, 10'd0, 12, "R6");
        run_buffer(wq.size() * 4, -5);
        check(tag_err, "R6", "foreign tag sets error", tag_err, 1);
        check(done_cnt == 0, "R6", "no completion for foreign tag", done_cnt, 0);

        // Buffer D: overrun (declared 48 bytes, packet needs 64 after record)
        pad_align = 8'd4; trailer_en = 1'b0;
        wq.push_back(32'h0000_0001);
        wq.push_back({11'd0, 5'd9, 16'd64});
        repeat (6) wq.push_back(32'h0);
        repeat (4) wq.push_back(32'hBAD0_0000);
        run_buffer(48, -5);
        check(overrun_err, "R10", "overrun flagged", overrun_err, 1);
        check(!tag_err && !busy, "R10", "overrun ends buffer, tag flag cleared (R1)",
              {tag_err, busy}, 0);

        // Buffer C: align 16 plus trailer, long pad skip
        pad_align = 8'd16; trailer_en = 1'b1;
        add_rec(8'h01, 8'h00, 16'h0000, 5'd9, 10'd0, 20, "R5");
        add_rec(8'h04, 8'h00, 16'h0000, 5'd9, 10'd0, 3, "R5");
        run_buffer(wq.size() * 4, -5);
        check(!overrun_err && !tag_err, "R5", "aligned spans fit exactly",
              {overrun_err, tag_err}, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule